// File: doc/BRIEF.md
# Read-Sequence Command Detector

This block sits beside a small static memory and watches the accesses made to it. It picks out a fixed unlock pattern made only of read accesses and, when the pattern completes, raises a one-clock request to copy the memory contents into nonvolatile storage (store) or to reload them from there (recall). The memory array, the output drivers, the nonvolatile timing and supply sensing all live elsewhere. A busy input from the nonvolatile controller holds the detector off while a transfer is running.

All strobes reach the block already synchronised to the system clock and are active low. An access is the chip-enable strobe going from inactive to active between two clock edges. The access is a read when write enable is inactive (high) at that edge, and a write otherwise. Five fixed prefix addresses must be read in strict order. The sixth read then chooses the command. Any other access on the way throws the progress away. The output-enable level plays no part in the pattern, so the block has no port for it.

Top module: `seqcmd_detect`

## Requirements
- R1: After reads at 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and then 0x0F0F, store_req_o is high for the one clock that follows the edge sampling the sixth read.
- R2: The same five prefix reads followed by a read at 0x0F0E raise recall_req_o for one clock in the same way.
- R3: A read counts once per chip-enable fall (ce_n_i sampled high and then low, with we_n_i high). Holding ce_n_i low across many clocks adds no further read.
- R4: A read at an address other than the one expected next aborts the sequence and no request follows. If the address is not 0x0000 the detector returns to idle.
- R5: A write aborts the sequence to idle. A write is a chip-enable fall with we_n_i low, or a we_n_i fall while ce_n_i is low.
- R6: A second read of the same address in a row, for example from a glitch on chip enable, aborts the sequence.
- R7: A sixth read at 0x139C, or at any address other than the two command addresses, raises neither request.
- R8: An aborting read at 0x0000 counts as the first step of a new sequence, so the next five correct reads complete a command.
- R9: While busy_i is high no request is raised, every access is ignored and the progress is cleared, so a sequence must start again from its first read.
- R10: store_req_o and recall_req_o are never high together, and neither stays high for two clocks in a row.
- R11: Synchronous reset (rst high) drives both requests low and clears the progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | 13 | Memory address, sampled with the chip-enable fall |
| ce_n_i | input | 1 | Synchronised chip enable, active low |
| we_n_i | input | 1 | Synchronised write enable, active low |
| busy_i | input | 1 | Nonvolatile transfer in progress |
| store_req_o | output | 1 | One-clock store command |
| recall_req_o | output | 1 | One-clock recall command |

## Verification
The progress counter is the only lasting state. A wrong value in it never shows until the sixth read: the port then gives a missing request, a request from too few reads, or the wrong command. The bench therefore ends every scenario with a command read and checks both request outputs in the clock just after it. A stray request also shows as a second high clock or as both requests at once, and the checker flags that in the cycle it happens.

// File: rtl/seqcmd_pkg.sv
package seqcmd_pkg;

    localparam int unsigned ADDR_W   = 13;
    localparam int unsigned PREFIX_N = 5;
    localparam int unsigned STEP_W   = $clog2(PREFIX_N + 1);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [STEP_W-1:0] step_t;

    localparam addr_t STORE_KEY  = addr_t'(13'h0F0F);
    localparam addr_t RECALL_KEY = addr_t'(13'h0F0E);

    // Unlock prefix, in the order it must be read.
    function automatic addr_t prefix_key(input int unsigned idx);
        case (idx)
            0:       prefix_key = addr_t'(13'h0000);
            1:       prefix_key = addr_t'(13'h1555);
            2:       prefix_key = addr_t'(13'h0AAA);
            3:       prefix_key = addr_t'(13'h1FFF);
            default: prefix_key = addr_t'(13'h10F0);
        endcase
    endfunction

    typedef struct packed {
        step_t step;
        logic  store;
        logic  recall;
    } det_state_t;

endpackage

// File: rtl/seqcmd_edge.sv
module seqcmd_edge #(
    parameter logic RESET_LVL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic sig_i,
    output logic fall_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig_i;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RESET_LVL;
        else     prev_q <= prev_d;
    end

    assign fall_o = prev_q & ~sig_i;
endmodule

// File: rtl/seqcmd_match.sv
module seqcmd_match
    import seqcmd_pkg::*;
(
    input  addr_t                addr_i,
    output logic [PREFIX_N-1:0]  prefix_hit_o,
    output logic                 store_hit_o,
    output logic                 recall_hit_o,
    output logic                 first_hit_o
);
    for (genvar i = 0; i < PREFIX_N; i++) begin : g_key
        assign prefix_hit_o[i] = (addr_i == prefix_key(i));
    end

    assign store_hit_o  = (addr_i == STORE_KEY);
    assign recall_hit_o = (addr_i == RECALL_KEY);
    assign first_hit_o  = prefix_hit_o[0];
endmodule

// File: rtl/seqcmd_detect.sv
module seqcmd_detect
    import seqcmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [12:0] addr_i,
    input  logic        ce_n_i,
    input  logic        we_n_i,
    input  logic        busy_i,
    output logic        store_req_o,
    output logic        recall_req_o
);
    logic                ce_fall, we_fall;
    logic                read_evt, write_evt;
    logic [PREFIX_N-1:0] prefix_hit;
    logic                store_hit, recall_hit, first_hit;
    logic                expect_hit;
    det_state_t          st_d, st_q;

    // Previous level reset to active so no edge is seen right after reset.
    seqcmd_edge #(.RESET_LVL(1'b0)) i_ce_edge (
        .clk(clk), .rst(rst), .sig_i(ce_n_i), .fall_o(ce_fall)
    );
    seqcmd_edge #(.RESET_LVL(1'b0)) i_we_edge (
        .clk(clk), .rst(rst), .sig_i(we_n_i), .fall_o(we_fall)
    );

    seqcmd_match i_match (
        .addr_i       (addr_t'(addr_i)),
        .prefix_hit_o (prefix_hit),
        .store_hit_o  (store_hit),
        .recall_hit_o (recall_hit),
        .first_hit_o  (first_hit)
    );

    assign read_evt  = ce_fall & we_n_i;
    assign write_evt = (ce_fall & ~we_n_i) | (we_fall & ~ce_n_i);

    always_comb begin
        expect_hit = 1'b0;
        for (int unsigned i = 0; i < PREFIX_N; i++) begin
            if (st_q.step == step_t'(i)) expect_hit = prefix_hit[i];
        end
    end

    always_comb begin
        st_d        = st_q;
        st_d.store  = 1'b0;
        st_d.recall = 1'b0;
        if (busy_i || write_evt) begin
            st_d.step = '0;
        end else if (read_evt) begin
            if (st_q.step == step_t'(PREFIX_N)) begin
                if (store_hit) begin
                    st_d.store = 1'b1;
                    st_d.step  = '0;
                end else if (recall_hit) begin
                    st_d.recall = 1'b1;
                    st_d.step   = '0;
                end else begin
                    st_d.step = first_hit ? step_t'(1) : step_t'(0);
                end
            end else if (expect_hit) begin
                st_d.step = step_t'(st_q.step + 1'b1);
            end else begin
                st_d.step = first_hit ? step_t'(1) : step_t'(0);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign store_req_o  = st_q.store;
    assign recall_req_o = st_q.recall;
endmodule

// File: rtl/seqcmd_detect_chk.sv
module seqcmd_detect_chk (
    input logic        clk,
    input logic        rst,
    input logic [12:0] addr_i,
    input logic        ce_n_i,
    input logic        we_n_i,
    input logic        busy_i,
    input logic        store_req_o,
    input logic        recall_req_o
);
    assert_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        !(store_req_o && recall_req_o));

    assert_store_single_R10: assert property (@(posedge clk) disable iff (rst)
        store_req_o |=> !store_req_o);

    assert_recall_single_R10: assert property (@(posedge clk) disable iff (rst)
        recall_req_o |=> !recall_req_o);

    assert_store_key_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(store_req_o) |-> ($past(addr_i) == 13'h0F0F && $past(we_n_i)
                                && !$past(ce_n_i) && !$past(busy_i)));

    assert_recall_key_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(recall_req_o) |-> ($past(addr_i) == 13'h0F0E && $past(we_n_i)
                                 && !$past(ce_n_i) && !$past(busy_i)));

    assert_busy_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        busy_i |=> (!store_req_o && !recall_req_o));

    assert_write_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (!ce_n_i && !we_n_i) |=> (!store_req_o && !recall_req_o));

    assert_reserved_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (addr_i == 13'h139C) |=> (!store_req_o && !recall_req_o));
endmodule

bind seqcmd_detect seqcmd_detect_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .addr_i       (addr_i),
    .ce_n_i       (ce_n_i),
    .we_n_i       (we_n_i),
    .busy_i       (busy_i),
    .store_req_o  (store_req_o),
    .recall_req_o (recall_req_o)
);

// File: tb/test_seqcmd_detect.sv
module test_seqcmd_detect;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] addr_i = '0;
    logic        ce_n_i = 1'b1;
    logic        we_n_i = 1'b1;
    logic        busy_i = 1'b0;
    logic        store_req_o, recall_req_o;

    int n_chk = 0;
    int n_err = 0;
    logic got_st, got_rc, aft_st, aft_rc;

    always #2 clk = ~clk;

    seqcmd_detect i_seqcmd_detect (
        .clk(clk), .rst(rst), .addr_i(addr_i), .ce_n_i(ce_n_i),
        .we_n_i(we_n_i), .busy_i(busy_i),
        .store_req_o(store_req_o), .recall_req_o(recall_req_o)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // One access: chip enable low for 1+hold clocks, outputs sampled one clock after the fall.
    task automatic acc(input logic [12:0] a, input bit wr, input int hold);
        @(negedge clk);
        addr_i = a; we_n_i = !wr; ce_n_i = 1'b0;
        @(negedge clk);
        got_st = store_req_o; got_rc = recall_req_o;
        repeat (hold) @(negedge clk);
        ce_n_i = 1'b1; we_n_i = 1'b1;
        @(negedge clk);
        aft_st = store_req_o; aft_rc = recall_req_o;
    endtask

    task automatic rd(input logic [12:0] a);
        acc(a, 1'b0, 0);
    endtask

    task automatic prefix();
        rd(13'h0000); rd(13'h1555); rd(13'h0AAA); rd(13'h1FFF); rd(13'h10F0);
    endtask

    task automatic t_reset();
        check("R11 store after reset", store_req_o, 1'b0);
        check("R11 recall after reset", recall_req_o, 1'b0);
        prefix();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(13'h0F0F);
        check("R11 progress cleared by reset", got_st, 1'b0);
    endtask

    task automatic t_store();
        prefix(); rd(13'h0F0F);
        check("R1 store pulse", got_st, 1'b1);
        check("R10 no recall with store", got_rc, 1'b0);
        check("R10 store one clock", aft_st, 1'b0);
    endtask

    task automatic t_recall();
        prefix(); rd(13'h0F0E);
        check("R2 recall pulse", got_rc, 1'b1);
        check("R10 no store with recall", got_st, 1'b0);
        check("R10 recall one clock", aft_rc, 1'b0);
    endtask

    task automatic t_hold_low();
        acc(13'h0000, 1'b0, 6);
        rd(13'h1555); rd(13'h0AAA); acc(13'h1FFF, 1'b0, 3); rd(13'h10F0);
        rd(13'h0F0F);
        check("R3 long enable counts once", got_st, 1'b1);
    endtask

    task automatic t_out_of_order();
        rd(13'h0000); rd(13'h1555); rd(13'h0AAA); rd(13'h1555);
        rd(13'h0AAA); rd(13'h1FFF); rd(13'h10F0); rd(13'h0F0F);
        check("R4 out-of-order aborts to idle", got_st, 1'b0);
        rd(13'h0000); rd(13'h1555); rd(13'h1FFF); rd(13'h10F0); rd(13'h0F0E);
        check("R4 skipped step gives no recall", got_rc, 1'b0);
    endtask

    task automatic t_repeat();
        rd(13'h0000); rd(13'h1555); rd(13'h1555);
        rd(13'h0AAA); rd(13'h1FFF); rd(13'h10F0); rd(13'h0F0F);
        check("R6 repeated read aborts", got_st, 1'b0);
    endtask

    task automatic t_write();
        rd(13'h0000); rd(13'h1555); acc(13'h0AAA, 1'b1, 0);
        rd(13'h1FFF); rd(13'h10F0); rd(13'h0F0F);
        check("R5 write on enable fall aborts", got_st, 1'b0);
        rd(13'h0000); rd(13'h1555); rd(13'h0AAA); rd(13'h1FFF);
        @(negedge clk); addr_i = 13'h10F0; we_n_i = 1'b1; ce_n_i = 1'b0;
        @(negedge clk); we_n_i = 1'b0;
        @(negedge clk); we_n_i = 1'b1; ce_n_i = 1'b1;
        rd(13'h0F0E);
        check("R5 write strobe inside read aborts", got_rc, 1'b0);
        rd(13'h0000); acc(13'h1555, 1'b1, 0);
        rd(13'h0000); rd(13'h1555); rd(13'h0AAA); rd(13'h1FFF); rd(13'h10F0);
        rd(13'h0F0F);
        check("R5 detector usable after write", got_st, 1'b1);
    endtask

    task automatic t_reserved();
        prefix(); rd(13'h139C);
        check("R7 reserved sixth no store", got_st, 1'b0);
        check("R7 reserved sixth no recall", got_rc, 1'b0);
        rd(13'h0F0F);
        check("R7 reserved ends progress", got_st, 1'b0);
        prefix(); rd(13'h0F0D);
        check("R7 other sixth no request", got_st | got_rc, 1'b0);
    endtask

    task automatic t_restart();
        rd(13'h0000); rd(13'h1555); rd(13'h0AAA); rd(13'h0000);
        rd(13'h1555); rd(13'h0AAA); rd(13'h1FFF); rd(13'h10F0); rd(13'h0F0F);
        check("R8 restart at step two", got_st, 1'b1);
        rd(13'h0000); rd(13'h0000);
        rd(13'h1555); rd(13'h0AAA); rd(13'h1FFF); rd(13'h10F0); rd(13'h0F0E);
        check("R8 repeated first address restarts", got_rc, 1'b1);
    endtask

    task automatic t_busy();
        @(negedge clk); busy_i = 1'b1;
        prefix(); rd(13'h0F0F);
        check("R9 busy blocks store", got_st, 1'b0);
        @(negedge clk); busy_i = 1'b0;
        rd(13'h0000); rd(13'h1555);
        @(negedge clk); busy_i = 1'b1;
        rd(13'h0AAA);
        @(negedge clk); busy_i = 1'b0;
        rd(13'h1FFF); rd(13'h10F0); rd(13'h0F0E);
        check("R9 busy clears progress", got_rc, 1'b0);
        prefix(); rd(13'h0F0E);
        check("R9 works after busy", got_rc, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_store();
        t_recall();
        t_hold_low();
        t_out_of_order();
        t_repeat();
        t_write();
        t_reserved();
        t_restart();
        t_busy();
        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule